// File: doc/BRIEF.md
# Control Endpoint OUT Data-Phase Tracker

This block follows the OUT data stage of a control transfer on endpoint 0. It sits between a packet receiver and an external master. The receiver supplies framed packets: a start strobe that carries a setup flag, one data beat per byte, then an end strobe. The master works through a small byte-wide register port. When a well-formed eight-byte setup packet ends, the block takes the expected data-stage length from its last two bytes and raises a setup interrupt. It then buffers each OUT packet of at most 64 bytes and raises a buffer interrupt. The master reads the packet's length, then pulls the bytes one at a time.

The block adds up the bytes that arrive across packets. When the total reaches the expected length, it finishes the status stage by itself with a one-cycle handshake strobe. A setup with no data stage waits for the master to write zero to the length register. The master can stall the transfer. A new setup that arrives at any time starts tracking again from the beginning.

Top module: `ep0_data_phase_tracker`

## Requirements
- R1: After reset, irq_setup_o, irq_buf_o, buf_full_o, ep_stall_o and hs_done_o are low, and reads of the length register (0x33) and of the interrupt register (0x35) return 0.
- R2: A setup packet of exactly 8 data beats takes the expected length as beat 6 (low byte) plus 256 times beat 7, raises irq_setup_o and sets bit 0 of register 0x35 from the cycle after its end strobe. A setup packet with any other beat count is ignored.
- R3: During the data stage, a packet that starts while the buffer is empty raises irq_buf_o and bit 1 of 0x35 at its end strobe. A read of 0x33 then returns its byte count, and buf_full_o is high when that count is nonzero.
- R4: Each read of 0x31 returns the next buffered byte in arrival order, on reg_rdata_o in the cycle after the read. buf_full_o falls once the last byte has been read.
- R5: A read of 0x31 when no unread byte remains returns 0x00 and changes no state.
- R6: A packet longer than 64 beats keeps its first 64 bytes, drops the rest, and reports a count of 64.
- R7: An OUT packet is ignored, with no interrupt and no change to the buffer, when it starts while the buffer still holds unread bytes, or when no data stage is open.
- R8: hs_done_o pulses for exactly one cycle, in the cycle after the end strobe of the packet that brings the running total up to or past the expected length. No pulse occurs before that, and the data stage then closes.
- R9: Writing 0x34 with bit 0 set raises ep_stall_o, which reads back as bit 0 of 0x34. It closes the data stage with no handshake. The next valid setup clears it.
- R10: A valid setup always restarts tracking: it clears the running total, empties the buffer (count 0), and raises the setup interrupt again.
- R11: After a setup whose expected length is 0, writing 0x00 to 0x33 produces the hs_done_o pulse in the next cycle. A nonzero write, or a write of zero while a data stage is open, produces none.
- R12: Both interrupt flags stay set until the master writes 0x35 with a 1 in the matching bit (bit 0 for setup, bit 1 for buffer). A 0 in a bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_sop_i | input | 1 | Packet start strobe (carries no data) |
| pkt_setup_i | input | 1 | With pkt_sop_i: the packet is a setup packet |
| pkt_valid_i | input | 1 | One data beat |
| pkt_data_i | input | 8 | Data byte of the beat |
| pkt_eop_i | input | 1 | Packet end strobe (carries no data) |
| reg_rd_i | input | 1 | Register read request |
| reg_wr_i | input | 1 | Register write request |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after reg_rd_i |
| irq_setup_o | output | 1 | Sticky setup-received interrupt |
| irq_buf_o | output | 1 | Sticky packet-buffered interrupt |
| buf_full_o | output | 1 | Buffer holds unread bytes |
| ep_stall_o | output | 1 | Transfer stalled |
| hs_done_o | output | 1 | One-cycle status-stage completion strobe |

## Verification
The assertions check several properties on every cycle. The handshake strobe never lasts two cycles, and it never appears while the endpoint is stalled. The buffer count never exceeds 64, and the read pointer never passes it. A read past the end returns zero. Both interrupt flags hold until an explicit clear. Only the bench's scenarios can show the rest: that the expected length is taken from the correct setup bytes, that the handshake arrives on the exact packet that meets the total for each length and packet size in the sweep, that bytes come out in order, and that blocked packets, restarts and zero-length acknowledgements behave as stated.

// File: rtl/ep0_trk_pkg.sv
package ep0_trk_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int SETUP_BEATS = 8;
  localparam int LEN_LO_BEAT = 6;
  localparam int LEN_HI_BEAT = 7;

  localparam logic [ADDR_W-1:0] A_DATA  = 8'h31;
  localparam logic [ADDR_W-1:0] A_COUNT = 8'h33;
  localparam logic [ADDR_W-1:0] A_STALL = 8'h34;
  localparam logic [ADDR_W-1:0] A_IRQ   = 8'h35;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DATA   = 2'd1,
    PH_NODATA = 2'd2
  } phase_e;
endpackage

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture
  import ep0_trk_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic              setup_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              eop_i,
  output logic              done_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             in_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      idx_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (sop_i) begin
        in_q  <= setup_i;
        idx_q <= '0;
      end else if (eop_i) begin
        in_q <= 1'b0;
      end else if (valid_i && in_q) begin
        if (idx_q == IDX_W'(LEN_LO_BEAT)) lo_q <= data_i;
        if (idx_q == IDX_W'(LEN_HI_BEAT)) hi_q <= data_i;
        if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign done_o = eop_i && in_q && (idx_q == IDX_W'(SETUP_BEATS));
  assign len_o  = LEN_W'({hi_q, lo_q});
endmodule

// File: rtl/ep0_pkt_buffer.sv
module ep0_pkt_buffer
  import ep0_trk_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic              setup_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              eop_i,
  input  logic              accept_i,
  input  logic              flush_i,
  input  logic              pop_i,
  output logic              pkt_end_o,
  output logic [CNT_W-1:0]  wr_cnt_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rd_ptr_o,
  output logic              full_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              in_q, full_q;
  logic [CNT_W-1:0]  wr_q, cnt_q, rd_q;
  logic              wr_en;

  assign wr_en     = valid_i && in_q && (wr_q < CAP);
  assign pkt_end_o = eop_i && in_q && accept_i;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q[IDX_W-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= 1'b0;
      full_q <= 1'b0;
      wr_q   <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else if (flush_i) begin
      in_q   <= 1'b0;
      full_q <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (sop_i) begin
        in_q <= !setup_i && accept_i && !full_q;
        wr_q <= '0;
      end else if (eop_i) begin
        in_q <= 1'b0;
        if (pkt_end_o) begin
          cnt_q  <= wr_q;
          rd_q   <= '0;
          full_q <= (wr_q != '0);
        end
      end else if (wr_en) begin
        wr_q <= wr_q + 1'b1;
      end
      if (pop_i && full_q) begin
        rd_q <= rd_q + 1'b1;
        if (rd_q + 1'b1 == cnt_q) full_q <= 1'b0;
      end
    end
  end

  assign wr_cnt_o = wr_q;
  assign cnt_o    = cnt_q;
  assign rd_ptr_o = rd_q;
  assign full_o   = full_q;
  assign rdata_o  = full_q ? mem_q[rd_q[IDX_W-1:0]] : '0;
endmodule

// File: rtl/ep0_xfer_ctrl.sv
module ep0_xfer_ctrl
  import ep0_trk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_done_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pkt_end_i,
  input  logic [CNT_W-1:0] pkt_cnt_i,
  input  logic             stall_req_i,
  input  logic             zlp_ack_i,
  output logic             accept_o,
  output logic             stall_o,
  output logic             hs_done_o
);
  localparam int SUM_W = LEN_W + 1;

  phase_e           phase_q;
  logic [LEN_W-1:0] len_q;
  logic [SUM_W-1:0] total_q, total_nxt;
  logic             stall_q, hs_q;

  assign total_nxt = total_q + SUM_W'(pkt_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      len_q   <= '0;
      total_q <= '0;
      stall_q <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      hs_q <= 1'b0;
      if (setup_done_i) begin
        phase_q <= (len_i == '0) ? PH_NODATA : PH_DATA;
        len_q   <= len_i;
        total_q <= '0;
        stall_q <= 1'b0;
      end else if (stall_req_i) begin
        stall_q <= 1'b1;
        phase_q <= PH_IDLE;
      end else if (phase_q == PH_DATA && pkt_end_i) begin
        total_q <= total_nxt;
        if (total_nxt >= SUM_W'(len_q)) begin
          hs_q    <= 1'b1;
          phase_q <= PH_IDLE;
        end
      end else if (phase_q == PH_NODATA && zlp_ack_i) begin
        hs_q    <= 1'b1;
        phase_q <= PH_IDLE;
      end
    end
  end

  assign accept_o  = (phase_q == PH_DATA);
  assign stall_o   = stall_q;
  assign hs_done_o = hs_q;
endmodule

// File: rtl/ep0_data_phase_tracker.sv
module ep0_data_phase_tracker
  import ep0_trk_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pkt_sop_i,
  input  logic        pkt_setup_i,
  input  logic        pkt_valid_i,
  input  logic [7:0]  pkt_data_i,
  input  logic        pkt_eop_i,
  input  logic        reg_rd_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        irq_setup_o,
  output logic        irq_buf_o,
  output logic        buf_full_o,
  output logic        ep_stall_o,
  output logic        hs_done_o
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic             setup_done, pkt_end, accept, stall_req, zlp_ack, pop;
  logic [LEN_W-1:0] setup_len;
  logic [CNT_W-1:0] wr_cnt, buf_cnt, buf_rd_ptr;
  logic [7:0]       buf_rdata;
  logic             irq_setup_q, irq_buf_q;
  logic [7:0]       rdata_q;

  assign pop       = reg_rd_i && (reg_addr_i == A_DATA);
  assign stall_req = reg_wr_i && (reg_addr_i == A_STALL) && reg_wdata_i[0];
  assign zlp_ack   = reg_wr_i && (reg_addr_i == A_COUNT) && (reg_wdata_i == 8'h00);

  ep0_setup_capture #(.LEN_W(LEN_W)) u_setup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sop_i   (pkt_sop_i),
    .setup_i (pkt_setup_i),
    .valid_i (pkt_valid_i),
    .data_i  (pkt_data_i),
    .eop_i   (pkt_eop_i),
    .done_o  (setup_done),
    .len_o   (setup_len)
  );

  ep0_pkt_buffer #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sop_i     (pkt_sop_i),
    .setup_i   (pkt_setup_i),
    .valid_i   (pkt_valid_i),
    .data_i    (pkt_data_i),
    .eop_i     (pkt_eop_i),
    .accept_i  (accept),
    .flush_i   (setup_done),
    .pop_i     (pop),
    .pkt_end_o (pkt_end),
    .wr_cnt_o  (wr_cnt),
    .cnt_o     (buf_cnt),
    .rd_ptr_o  (buf_rd_ptr),
    .full_o    (buf_full_o),
    .rdata_o   (buf_rdata)
  );

  ep0_xfer_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .setup_done_i (setup_done),
    .len_i        (setup_len),
    .pkt_end_i    (pkt_end),
    .pkt_cnt_i    (wr_cnt),
    .stall_req_i  (stall_req),
    .zlp_ack_i    (zlp_ack),
    .accept_o     (accept),
    .stall_o      (ep_stall_o),
    .hs_done_o    (hs_done_o)
  );

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_setup_q <= 1'b0;
      irq_buf_q   <= 1'b0;
    end else begin
      if (setup_done) irq_setup_q <= 1'b1;
      else if (reg_wr_i && reg_addr_i == A_IRQ && reg_wdata_i[0]) irq_setup_q <= 1'b0;
      if (pkt_end) irq_buf_q <= 1'b1;
      else if (reg_wr_i && reg_addr_i == A_IRQ && reg_wdata_i[1]) irq_buf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      case (reg_addr_i)
        A_DATA:  rdata_q <= buf_rdata;
        A_COUNT: rdata_q <= 8'(buf_cnt);
        A_STALL: rdata_q <= {7'b0, ep_stall_o};
        A_IRQ:   rdata_q <= {6'b0, irq_buf_q, irq_setup_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_setup_o = irq_setup_q;
  assign irq_buf_o   = irq_buf_q;
endmodule

// File: rtl/ep0_trk_chk.sv
module ep0_trk_chk #(
  parameter int BUF_DEPTH = 64,
  parameter int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_rd_i,
  input logic             reg_wr_i,
  input logic [7:0]       reg_addr_i,
  input logic [1:0]       reg_wbits,
  input logic [7:0]       reg_rdata_o,
  input logic             irq_setup_o,
  input logic             irq_buf_o,
  input logic             buf_full_o,
  input logic             ep_stall_o,
  input logic             hs_done_o,
  input logic [CNT_W-1:0] buf_cnt,
  input logic [CNT_W-1:0] buf_rd_ptr
);
  logic irq_wr;
  assign irq_wr = reg_wr_i && (reg_addr_i == 8'h35);

  assert_hs_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_done_o |=> !hs_done_o);

  assert_cnt_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_cnt <= CNT_W'(BUF_DEPTH));

  assert_ptr_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_ptr <= buf_cnt);

  assert_empty_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 8'h31 && !buf_full_o) |=> (reg_rdata_o == 8'h00));

  assert_full_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> (buf_cnt != '0));

  assert_stall_no_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_stall_o |-> !hs_done_o);

  assert_setup_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_setup_o && !(irq_wr && reg_wbits[0])) |=> irq_setup_o);

  assert_buf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_buf_o && !(irq_wr && reg_wbits[1])) |=> irq_buf_o);
endmodule

bind ep0_data_phase_tracker ep0_trk_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wbits   (reg_wdata_i[1:0]),
  .reg_rdata_o (reg_rdata_o),
  .irq_setup_o (irq_setup_o),
  .irq_buf_o   (irq_buf_o),
  .buf_full_o  (buf_full_o),
  .ep_stall_o  (ep_stall_o),
  .hs_done_o   (hs_done_o),
  .buf_cnt     (buf_cnt),
  .buf_rd_ptr  (buf_rd_ptr)
);

// File: tb/sim_ep0_data_phase_tracker.sv
module sim_ep0_data_phase_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pkt_sop_i = 0, pkt_setup_i = 0, pkt_valid_i = 0, pkt_eop_i = 0;
  logic [7:0] pkt_data_i = 0;
  logic       reg_rd_i = 0, reg_wr_i = 0;
  logic [7:0] reg_addr_i = 0, reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       irq_setup_o, irq_buf_o, buf_full_o, ep_stall_o, hs_done_o;

  int n_chk = 0;
  int n_err = 0;
  int hs_cnt = 0;

  always #2 clk_i = ~clk_i;

  ep0_data_phase_tracker u0 (.*);

  always @(negedge clk_i) if (hs_done_o) hs_cnt++;

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int base, input int i);
    return 8'((base * 29 + i * 7 + 3) & 255);
  endfunction

  task automatic send_pkt(input bit setup, input int n, input int base);
    pkt_sop_i = 1; pkt_setup_i = setup; tick; pkt_sop_i = 0; pkt_setup_i = 0;
    for (int i = 0; i < n; i++) begin
      pkt_valid_i = 1; pkt_data_i = bval(base, i); tick;
    end
    pkt_valid_i = 0;
    pkt_eop_i = 1; tick; pkt_eop_i = 0;
  endtask

  task automatic send_setup(input int len, input int beats);
    pkt_sop_i = 1; pkt_setup_i = 1; tick; pkt_sop_i = 0; pkt_setup_i = 0;
    for (int i = 0; i < beats; i++) begin
      pkt_valid_i = 1;
      pkt_data_i = (i == 6) ? 8'(len & 255) : (i == 7) ? 8'((len >> 8) & 255) : 8'(8'h40 + i);
      tick;
    end
    pkt_valid_i = 0;
    pkt_eop_i = 1; tick; pkt_eop_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_rd_i = 1; reg_addr_i = a; tick; v = int'(reg_rdata_o); reg_rd_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d; tick; reg_wr_i = 0;
  endtask

  task automatic done;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=1 expected=0");
    done();
  end

  initial begin
    int v, h0, rem, n, pk;
    int lens[5] = '{1, 5, 64, 65, 300};
    int psz[2]  = '{64, 17};
    tick; tick;
    rst_ni = 1; tick;
    // R1
    chk("R1 irq_setup", int'(irq_setup_o), 0);
    chk("R1 irq_buf", int'(irq_buf_o), 0);
    chk("R1 full", int'(buf_full_o), 0);
    chk("R1 stall", int'(ep_stall_o), 0);
    chk("R1 hs", int'(hs_done_o), 0);
    rd(8'h33, v); chk("R1 count", v, 0);
    rd(8'h35, v); chk("R1 irqreg", v, 0);

    // R2 R3 R4 R8 sweep over lengths and packet sizes
    foreach (lens[li]) foreach (psz[pi]) begin
      wr(8'h35, 8'h03);
      send_setup(lens[li], 8);
      chk("R2 setup irq", int'(irq_setup_o), 1);
      rd(8'h35, v); chk("R2 irqreg bit0", v & 1, 1);
      wr(8'h35, 8'h01);
      chk("R12 cleared", int'(irq_setup_o), 0);
      h0 = hs_cnt; rem = lens[li]; pk = 0;
      while (rem > 0) begin
        n = (rem < psz[pi]) ? rem : psz[pi];
        send_pkt(0, n, pk + lens[li]);
        chk("R8 hs timing", int'(hs_done_o), (rem == n) ? 1 : 0);
        chk("R3 irq_buf", int'(irq_buf_o), 1);
        chk("R3 full", int'(buf_full_o), 1);
        rd(8'h33, v); chk("R3 count", v, n);
        for (int i = 0; i < n; i++) begin
          rd(8'h31, v); chk("R4 byte", v, int'(bval(pk + lens[li], i)));
        end
        chk("R4 drained", int'(buf_full_o), 0);
        wr(8'h35, 8'h02);
        rem -= n; pk++;
      end
      tick;
      chk("R8 one pulse", hs_cnt - h0, 1);
    end

    // R2 malformed setups
    wr(8'h35, 8'h03);
    send_setup(10, 7); tick;
    chk("R2 short setup", int'(irq_setup_o), 0);
    send_setup(10, 9); tick;
    chk("R2 long setup", int'(irq_setup_o), 0);

    // R6 R5 oversize packet
    send_setup(100, 8); h0 = hs_cnt;
    send_pkt(0, 70, 9);
    rd(8'h33, v); chk("R6 capped count", v, 64);
    for (int i = 0; i < 64; i++) begin
      rd(8'h31, v); chk("R6 byte", v, int'(bval(9, i)));
    end
    rd(8'h31, v); chk("R5 past end", v, 0);
    rd(8'h31, v); chk("R5 past end again", v, 0);
    rd(8'h33, v); chk("R5 count kept", v, 64);
    chk("R8 no early hs", hs_cnt - h0, 0);

    // R7 blocked while full, then outside data stage
    send_setup(50, 8); h0 = hs_cnt;
    send_pkt(0, 3, 1);
    wr(8'h35, 8'h02);
    send_pkt(0, 5, 2);
    chk("R7 no irq when full", int'(irq_buf_o), 0);
    rd(8'h33, v); chk("R7 count kept", v, 3);
    for (int i = 0; i < 3; i++) begin
      rd(8'h31, v); chk("R7 first pkt", v, int'(bval(1, i)));
    end
    send_pkt(0, 47, 3);
    chk("R8 hs at total", int'(hs_done_o), 1);
    for (int i = 0; i < 47; i++) rd(8'h31, v);
    wr(8'h35, 8'h02);
    send_pkt(0, 4, 4);
    chk("R7 idle irq", int'(irq_buf_o), 0);
    chk("R7 idle full", int'(buf_full_o), 0);
    rd(8'h33, v); chk("R7 idle count", v, 47);
    chk("R8 one pulse", hs_cnt - h0, 1);

    // R9 stall
    send_setup(100, 8); h0 = hs_cnt;
    wr(8'h34, 8'h01);
    chk("R9 stall out", int'(ep_stall_o), 1);
    rd(8'h34, v); chk("R9 stall reg", v, 1);
    wr(8'h35, 8'h02);
    send_pkt(0, 64, 5);
    send_pkt(0, 64, 6);
    chk("R9 no buf irq", int'(irq_buf_o), 0);
    chk("R9 no hs", hs_cnt - h0, 0);
    send_setup(0, 8);
    chk("R9 cleared by setup", int'(ep_stall_o), 0);

    // R10 restart
    send_setup(100, 8); h0 = hs_cnt;
    send_pkt(0, 64, 7);
    for (int i = 0; i < 64; i++) rd(8'h31, v);
    wr(8'h35, 8'h03);
    send_setup(100, 8);
    chk("R10 setup irq", int'(irq_setup_o), 1);
    send_pkt(0, 64, 8);
    chk("R10 total cleared", int'(hs_done_o), 0);
    for (int i = 0; i < 64; i++) rd(8'h31, v);
    send_pkt(0, 36, 9);
    chk("R10 hs after full length", int'(hs_done_o), 1);
    for (int i = 0; i < 36; i++) rd(8'h31, v);
    send_setup(20, 8);
    send_pkt(0, 10, 10);
    send_setup(20, 8);
    chk("R10 flush full", int'(buf_full_o), 0);
    rd(8'h33, v); chk("R10 flush count", v, 0);

    // R11 zero-length acknowledge
    h0 = hs_cnt;
    wr(8'h33, 8'h00);
    chk("R11 zero write in data stage", int'(hs_done_o), 0);
    send_setup(0, 8);
    wr(8'h33, 8'h05);
    chk("R11 nonzero write", int'(hs_done_o), 0);
    wr(8'h33, 8'h00);
    chk("R11 ack hs", int'(hs_done_o), 1);
    tick;
    chk("R11 single pulse", hs_cnt - h0, 1);

    // R12 sticky flags
    wr(8'h35, 8'h03);
    send_setup(4, 8);
    send_pkt(0, 4, 11);
    tick; tick; tick;
    chk("R12 setup held", int'(irq_setup_o), 1);
    chk("R12 buf held", int'(irq_buf_o), 1);
    wr(8'h35, 8'h02);
    chk("R12 setup kept", int'(irq_setup_o), 1);
    chk("R12 buf cleared", int'(irq_buf_o), 0);
    wr(8'h35, 8'h01);
    chk("R12 setup cleared", int'(irq_setup_o), 0);
    done();
  end
endmodule